// File: doc/BRIEF.md
# Tape block checksum accumulator

This block builds the checksum of one 18-bit tape data block while the words stream past, one word per clock at most. A start pulse opens a block, seeds the accumulator and latches which of two checksum styles applies. A finish pulse closes the block. One cycle later a done flag pulses, and the checksum output then holds its value until the next start.

The first style is a 6-bit fold. Each word is bitwise inverted and cut into three 6-bit slices, and all three slices are XORed into a 6-bit accumulator seeded with all ones. The second style is an 18-bit one's-complement sum. The accumulator is seeded with all ones, every carry out of the top bit is wrapped back into bit 0, and the reported checksum is the inverse of the accumulator. The block sees only data words, in order. Tape motion, framing of headers and memory transfers are handled elsewhere.

Top module: `tape_csum_acc`

## Requirements
- R1: While reset is held low, csum_o is 0 and done_o is 0.
- R2: A start pulse with mode_i = 0 (fold) makes csum_o read octal 77 from the next cycle. A start pulse with mode_i = 1 (sum) makes csum_o read 0 from the next cycle, because all 18 accumulator bits are set.
- R3: In fold mode, each accepted word w updates the 6-bit accumulator a to a ^ ~w[17:12] ^ ~w[11:6] ^ ~w[5:0].
- R4: In fold mode, csum_o[5:0] is the accumulator with no final inversion, and csum_o[17:6] is 0.
- R5: In sum mode, each accepted word is added to the 18-bit accumulator, and a carry out of bit 17 is added back into bit 0.
- R6: In sum mode, csum_o is the bitwise complement of the 18-bit accumulator.
- R7: A word is accepted only in a cycle where word_valid_i is high inside an open block, at most one per clock. When word_valid_i is low, the accumulator does not change.
- R8: A start in the same cycle as a valid word reseeds the accumulator, and that word is discarded.
- R9: done_o is high for exactly the one cycle after a finish pulse that closes an open block. A word accepted in the finish cycle is included in the result.
- R10: After a block closes, csum_o keeps its value and further valid words are ignored until the next start.
- R11: mode_i is sampled only at start. Changing it inside a block has no effect on the result.
- R12: A finish pulse with no open block (before any start, or after a block has closed) produces no done_o pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a block, seeds the accumulator, latches mode |
| mode_i | input | 1 | Checksum style: 0 = 6-bit fold, 1 = one's-complement sum |
| word_valid_i | input | 1 | word_i holds a data word this cycle |
| word_i | input | 18 | Data word |
| finish_i | input | 1 | Closes the open block |
| csum_o | output | 18 | Checksum (6-bit fold in bits 5:0, or 18-bit sum) |
| done_o | output | 1 | One-cycle pulse after the block closes |

## Verification
csum_o follows the accumulator with no register in between. A bad seed, a dropped or doubled word, or a lost end-around carry therefore shows at the port in the cycle right after the edge that caused it. Because of this, the bench compares csum_o after every word instead of only at done. A mode latch that drifts shows up as fold results that carry nonzero upper bits, or as sum results. A block that fails to close shows up as a checksum that keeps moving after done.

// File: rtl/tape_csum_pkg.sv
package tape_csum_pkg;
  typedef enum logic {
    CS_FOLD = 1'b0,
    CS_SUM  = 1'b1
  } cs_mode_e;
endpackage

// File: rtl/csum_fold_step.sv
module csum_fold_step #(
  parameter int WORD_W  = 18,
  parameter int SLICE_W = 6
) (
  input  logic [SLICE_W-1:0] acc_i,
  input  logic [WORD_W-1:0]  word_i,
  output logic [SLICE_W-1:0] next_o
);
  localparam int NSLICE = WORD_W / SLICE_W;

  logic [NSLICE-1:0][SLICE_W-1:0] inv_slice;

  for (genvar g = 0; g < NSLICE; g++) begin : g_slice
    assign inv_slice[g] = ~word_i[g*SLICE_W +: SLICE_W];
  end

  always_comb begin
    next_o = acc_i;
    for (int k = 0; k < NSLICE; k++) next_o = next_o ^ inv_slice[k];
  end
endmodule

// File: rtl/csum_eac_step.sv
module csum_eac_step #(
  parameter int WORD_W = 18
) (
  input  logic [WORD_W-1:0] acc_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WORD_W-1:0] next_o
);
  logic [WORD_W:0] raw_sum;

  assign raw_sum = {1'b0, acc_i} + {1'b0, word_i};
  // end-around carry; the second add cannot carry again
  assign next_o  = raw_sum[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, raw_sum[WORD_W]};
endmodule

// File: rtl/tape_csum_acc.sv
module tape_csum_acc
  import tape_csum_pkg::*;
#(
  parameter int WORD_W  = 18,
  parameter int SLICE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              mode_i,
  input  logic              word_valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              finish_i,
  output logic [WORD_W-1:0] csum_o,
  output logic              done_o
);
  localparam int UPPER_W = WORD_W - SLICE_W;
  localparam logic [WORD_W-1:0] FOLD_SEED = {{UPPER_W{1'b0}}, {SLICE_W{1'b1}}};
  localparam logic [WORD_W-1:0] SUM_SEED  = {WORD_W{1'b1}};

  cs_mode_e            mode_q;
  logic [WORD_W-1:0]   acc_q;
  logic                open_q;
  logic                done_q;
  logic [SLICE_W-1:0]  fold_next;
  logic [WORD_W-1:0]   sum_next;
  logic                take;

  csum_fold_step #(.WORD_W(WORD_W), .SLICE_W(SLICE_W)) u_fold (
    .acc_i  (acc_q[SLICE_W-1:0]),
    .word_i (word_i),
    .next_o (fold_next)
  );

  csum_eac_step #(.WORD_W(WORD_W)) u_eac (
    .acc_i  (acc_q),
    .word_i (word_i),
    .next_o (sum_next)
  );

  assign take = open_q && word_valid_i && !start_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= CS_FOLD;
      acc_q  <= '0;
      open_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish_i && open_q && !start_i;
      if (start_i) begin
        mode_q <= cs_mode_e'(mode_i);
        acc_q  <= mode_i ? SUM_SEED : FOLD_SEED;
        open_q <= 1'b1;
      end else begin
        if (take)
          acc_q <= (mode_q == CS_SUM) ? sum_next : {{UPPER_W{1'b0}}, fold_next};
        if (finish_i) open_q <= 1'b0;
      end
    end
  end

  assign csum_o = (mode_q == CS_SUM) ? ~acc_q : {{UPPER_W{1'b0}}, acc_q[SLICE_W-1:0]};
  assign done_o = done_q;

  p_seed_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (csum_o == ($past(mode_i) ? '0 : FOLD_SEED)));

  p_fold_upper_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == CS_FOLD) |-> (csum_o[WORD_W-1:SLICE_W] == '0));

  p_idle_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!word_valid_i && !start_i) |=> $stable(acc_q));

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_hold_closed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_q && !start_i) |=> $stable(csum_o));

  p_mode_latch_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(mode_q));

  p_no_orphan_done_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!open_q) |=> !done_o);
endmodule

// File: tb/tape_csum_acc_tb.sv
module tape_csum_acc_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 18;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0, mode = 1'b0, valid = 1'b0, finish = 1'b0;
  logic [W-1:0] word = '0;
  logic [W-1:0] csum;
  logic         done;
  int           n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tape_csum_acc u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .mode_i(mode),
    .word_valid_i(valid), .word_i(word), .finish_i(finish),
    .csum_o(csum), .done_o(done)
  );

  function automatic logic [5:0] ref_fold(input logic [5:0] a, input logic [W-1:0] w);
    logic [W-1:0] nw;
    nw = ~w;
    return a ^ nw[17:12] ^ nw[11:6] ^ nw[5:0];
  endfunction

  function automatic logic [W-1:0] ref_sum(input logic [W-1:0] a, input logic [W-1:0] w);
    logic [W:0] s;
    s = {1'b0, a} + {1'b0, w};
    if (s[W]) return s[W-1:0] + 1'b1;
    return s[W-1:0];
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %o expected %o", tag, act, exp);
    end
  endtask

  // inputs change at negedge; the following negedge sees the result of the edge between
  task automatic drive(input logic st, input logic md, input logic vl,
                       input logic [W-1:0] d, input logic fin);
    start = st; mode = md; valid = vl; word = d; finish = fin;
    @(negedge clk);
  endtask

  task automatic idle();
    drive(1'b0, mode, 1'b0, '0, 1'b0);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic t_reset();
    check("R1 csum in reset", csum, '0);
    check("R1 done in reset", {17'b0, done}, '0);
  endtask

  task automatic t_orphan_finish();
    drive(1'b0, 1'b0, 1'b0, '0, 1'b1);
    check("R12 finish before start", {17'b0, done}, '0);
    idle();
  endtask

  task automatic t_fold_block();
    logic [5:0] a;
    drive(1'b1, 1'b0, 1'b0, '0, 1'b0);
    check("R2 fold seed", csum, 18'o77);
    a = 6'o77;
    drive(1'b0, 1'b0, 1'b1, 18'o123456, 1'b0);
    a = ref_fold(a, 18'o123456);
    check("R3 fold word1", csum, {12'b0, a});
    drive(1'b0, 1'b0, 1'b1, 18'o000000, 1'b0);
    a = ref_fold(a, 18'o000000);
    check("R3 fold word2", csum, {12'b0, a});
    drive(1'b0, 1'b0, 1'b1, 18'o777777, 1'b1);
    a = ref_fold(a, 18'o777777);
    check("R9 done after finish", {17'b0, done}, 18'd1);
    check("R4 fold result no inversion", csum, 18'o000007);
    check("R4 fold upper zero", {6'b0, csum[17:6]}, '0);
    idle();
    check("R9 done one cycle", {17'b0, done}, '0);
  endtask

  task automatic t_sum_block();
    drive(1'b1, 1'b1, 1'b0, '0, 1'b0);
    check("R2 sum seed", csum, '0);
    drive(1'b0, 1'b1, 1'b1, 18'o000001, 1'b0);
    check("R5 sum with wrap", csum, 18'o777776);
    drive(1'b0, 1'b1, 1'b1, 18'o777777, 1'b0);
    check("R5 end-around carry", csum, 18'o777776);
    drive(1'b0, 1'b1, 1'b1, 18'o000005, 1'b1);
    check("R6 sum complement", csum, 18'o777771);
    check("R9 done sum", {17'b0, done}, 18'd1);
    idle();
  endtask

  task automatic t_valid_gate();
    logic [W-1:0] a;
    drive(1'b1, 1'b1, 1'b0, '0, 1'b0);
    drive(1'b0, 1'b1, 1'b0, 18'o012345, 1'b0);
    drive(1'b0, 1'b1, 1'b0, 18'o054321, 1'b0);
    check("R7 no valid no change", csum, '0);
    a = '1;
    drive(1'b0, 1'b1, 1'b1, 18'o000010, 1'b0);
    a = ref_sum(a, 18'o000010);
    drive(1'b0, 1'b1, 1'b1, 18'o000020, 1'b0);
    a = ref_sum(a, 18'o000020);
    check("R7 back-to-back words", csum, ~a);
    check("R7 back-to-back literal", csum, 18'o777747);
    drive(1'b0, 1'b1, 1'b0, '0, 1'b1);
    idle();
  endtask

  task automatic t_start_priority();
    drive(1'b1, 1'b1, 1'b0, '0, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 18'o000100, 1'b0);
    check("R8 pre-accumulate", csum, 18'o777677);
    drive(1'b1, 1'b0, 1'b1, 18'o123456, 1'b0);
    check("R8 start wins over word", csum, 18'o77);
    drive(1'b0, 1'b0, 1'b0, '0, 1'b1);
    idle();
  endtask

  task automatic t_hold();
    drive(1'b1, 1'b1, 1'b0, '0, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 18'o000005, 1'b1);
    check("R10 result at done", csum, 18'o777772);
    for (int i = 0; i < 3; i++) begin
      drive(1'b0, 1'b1, 1'b1, 18'o000700 + 18'(i), 1'b0);
      check("R10 ignored after close", csum, 18'o777772);
    end
    drive(1'b0, 1'b1, 1'b1, 18'o000001, 1'b1);
    check("R12 finish after close", {17'b0, done}, '0);
    check("R10 hold after second finish", csum, 18'o777772);
    idle();
  endtask

  task automatic t_mode_latch();
    drive(1'b1, 1'b0, 1'b0, '0, 1'b0);
    drive(1'b0, 1'b1, 1'b1, 18'o123456, 1'b0);
    check("R11 mode change ignored", csum, {12'b0, ref_fold(6'o77, 18'o123456)});
    drive(1'b0, 1'b1, 1'b1, 18'o000777, 1'b1);
    check("R11 fold kept to end", csum,
          {12'b0, ref_fold(ref_fold(6'o77, 18'o123456), 18'o000777)});
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_orphan_finish();
    t_fold_block();
    t_sum_block();
    t_valid_gate();
    t_start_priority();
    t_hold();
    t_mode_latch();
    report();
  end
endmodule